// File: doc/BRIEF.md
# Prime-Field Adder-Subtractor (256-bit, gate level)

This block adds or subtracts two 256-bit field elements modulo the prime p = 2^256 − 2^32 − 977. Both operands must already lie in [0, p). The result comes back reduced into the same range. The unit is purely combinational: there is no clock, no storage and no feedback from any gate output to an earlier input. It is meant to sit inside a larger elliptic-curve datapath, where a single operation select picks the operation in the same cycle as the operands.

All arithmetic is spelled out as explicit two-input gates and inverters, so the gate count can be read straight from the netlist.

- **Adders:** the adders are ripple chains of full-adder cells, each cell made of two XOR, two AND and one OR gate. A chain with no incoming carry starts with a half adder (one XOR, one AND).
- **Reduction:** the block computes both the raw value and the value corrected by p. A per-bit AND/AND/OR multiplexer then keeps one of them, and a single inverter makes the complementary select.
- **Addition path:** the sum a + b keeps its carry-out, which acts as a 257th bit. Then p is subtracted from it. The corrected value is chosen when the extended subtraction does not borrow, that is when a + b ≥ p.
- **Subtraction path:** the minuend is added to the inverted subtrahend with the carry-in forced to one. When that borrows, p is added back.

Top module: `modp_addsub`

## Requirements
- R1: With op_sub_i = 0 the output res_o equals (a_i + b_i) mod p for any a_i, b_i in [0, p).
- R2: With op_sub_i = 1 the output res_o equals (a_i − b_i) mod p, taken into [0, p), for any a_i, b_i in [0, p).
- R3: For operands in [0, p) the output is always strictly below p.
- R4: An addition whose exact sum is p yields 0.
- R5: Subtracting an operand from itself yields 0.
- R6: An addition whose exact sum reaches or passes 2^256 is reduced correctly; for example (p−1) + (p−1) gives p − 2.
- R7: Subtracting from a zero minuend gives p − b_i; in particular 0 − (p−1) gives 1, and 0 − 0 gives 0.
- R8: The output depends only on the present inputs: it settles within the same time step without any clock, and the same inputs always give the same output whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sub_i | input | 1 | Operation select: 0 = add, 1 = subtract |
| a_i | input | 256 | First operand, reduced below p |
| b_i | input | 256 | Second operand, reduced below p |
| res_o | output | 256 | Reduced result in [0, p) |

## Verification
The bench aims at the two reduction boundaries: a sum landing exactly on p, and a sum that spills past 2^256.

- **Sum equal to p:** a design that tested s > p instead of s ≥ p would return p there instead of 0.
- **Sum past 2^256:** a design that dropped the carry-out of a + b would return a value 2^256 − p too small, or fail to reduce at all.
- **Borrowing subtraction:** cases with a zero minuend and with equal operands catch a mis-driven correction select. Such a design would return the raw wrapped difference, or add p when nothing borrowed, giving values at or above p.
- **Mixed random vectors:** random reduced vectors in both modes catch a broken carry link in any single ripple cell.

// File: rtl/modp_pkg.sv
package modp_pkg;
  // Field width and the prime 2^256 - 2^32 - 977 derived from it.
  localparam int FIELD_W = 256;
  localparam logic [FIELD_W-1:0] FIELD_P = ~FIELD_W'(0) - FIELD_W'(64'h1_0000_03D0);
endpackage

// File: rtl/ha_cell.sv
module ha_cell (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  // One XOR, one AND.
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p_xy;
  logic g_xy;
  logic g_pc;
  // Two XOR, two AND, one OR.
  assign p_xy = x ^ y;
  assign s    = p_xy ^ ci;
  assign g_xy = x & y;
  assign g_pc = p_xy & ci;
  assign co   = g_xy | g_pc;
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N:0] cy;
  assign cy[0] = cin;

  for (genvar i = 0; i < N; i++) begin : g_cell
    fa_cell u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (cy[i]),
      .s  (sum[i]),
      .co (cy[i+1])
    );
  end

  assign cout = cy[N];
endmodule

// File: rtl/gate_mux2.sv
module gate_mux2 #(
  parameter int N = 8
) (
  input  logic         sel,
  input  logic [N-1:0] d1,
  input  logic [N-1:0] d0,
  output logic [N-1:0] q
);
  logic sel_n;
  assign sel_n = ~sel;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic t1;
    logic t0;
    assign t1   = d1[i] & sel;
    assign t0   = d0[i] & sel_n;
    assign q[i] = t1 | t0;
  end
endmodule

// File: rtl/modp_addsub.sv
module modp_addsub #(
  parameter int             W     = modp_pkg::FIELD_W,
  parameter logic [W-1:0]   PRIME = modp_pkg::FIELD_P
) (
  input  logic         op_sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam logic [W-1:0] PRIME_N = ~PRIME;

  // ---------------- addition path: s = a + b, t = s - p ----------------
  logic [W-1:0] s_val;
  logic         s_c0;
  logic         s_cout;

  ha_cell u_s_ha (
    .x (a_i[0]),
    .y (b_i[0]),
    .s (s_val[0]),
    .c (s_c0)
  );

  ripple_chain #(.N(W-1)) u_s_chain (
    .x    (a_i[W-1:1]),
    .y    (b_i[W-1:1]),
    .cin  (s_c0),
    .sum  (s_val[W-1:1]),
    .cout (s_cout)
  );

  logic [W-1:0] t_val;
  logic         t_cout;

  ripple_chain #(.N(W)) u_t_chain (
    .x    (s_val),
    .y    (PRIME_N),
    .cin  (1'b1),
    .sum  (t_val),
    .cout (t_cout)
  );

  // 257-bit no-borrow: bit W of ~p is 1, so carry out = s_cout | t_cout.
  logic add_ge_p;
  assign add_ge_p = s_cout | t_cout;

  logic [W-1:0] add_res;
  gate_mux2 #(.N(W)) u_add_sel (
    .sel (add_ge_p),
    .d1  (t_val),
    .d0  (s_val),
    .q   (add_res)
  );

  // ---------------- subtraction path: d = a - b, e = d + p ----------------
  logic [W-1:0] b_inv;
  assign b_inv = ~b_i;

  logic [W-1:0] d_val;
  logic         d_cout;

  ripple_chain #(.N(W)) u_d_chain (
    .x    (a_i),
    .y    (b_inv),
    .cin  (1'b1),
    .sum  (d_val),
    .cout (d_cout)
  );

  logic [W-1:0] e_val;
  logic         e_c0;
  logic         e_cout;

  ha_cell u_e_ha (
    .x (d_val[0]),
    .y (PRIME[0]),
    .s (e_val[0]),
    .c (e_c0)
  );

  ripple_chain #(.N(W-1)) u_e_chain (
    .x    (d_val[W-1:1]),
    .y    (PRIME[W-1:1]),
    .cin  (e_c0),
    .sum  (e_val[W-1:1]),
    .cout (e_cout)
  );

  // Borrow occurred (no carry from d); the wrap of e confirms the correction.
  logic d_borrow;
  logic sub_fix;
  assign d_borrow = ~d_cout;
  assign sub_fix  = d_borrow & e_cout;

  logic [W-1:0] sub_res;
  gate_mux2 #(.N(W)) u_sub_sel (
    .sel (sub_fix),
    .d1  (e_val),
    .d0  (d_val),
    .q   (sub_res)
  );

  // ---------------- operation select ----------------
  gate_mux2 #(.N(W)) u_op_sel (
    .sel (op_sub_i),
    .d1  (sub_res),
    .d0  (add_res),
    .q   (res_o)
  );
endmodule

// File: rtl/modp_addsub_chk.sv
module modp_addsub_chk #(
  parameter int           W     = modp_pkg::FIELD_W,
  parameter logic [W-1:0] PRIME = modp_pkg::FIELD_P
) (
  input logic         op_sub_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o
);
  logic [W:0] ext_a;
  logic [W:0] ext_b;
  logic [W:0] ext_p;
  logic [W:0] ext_r;
  logic       in_range;

  assign ext_a    = {1'b0, a_i};
  assign ext_b    = {1'b0, b_i};
  assign ext_p    = {1'b0, PRIME};
  assign ext_r    = {1'b0, res_o};
  assign in_range = (a_i < PRIME) && (b_i < PRIME) && !$isunknown({op_sub_i, a_i, b_i});

  always_comb begin
    if (in_range) begin
      // R1
      add_mod_chk: assert (op_sub_i || ext_r == (ext_a + ext_b) % ext_p);
      // R2
      sub_mod_chk: assert (!op_sub_i || ext_r == (ext_a + ext_p - ext_b) % ext_p);
      // R3
      range_chk: assert (res_o < PRIME);
      // R4
      sum_is_p_chk: assert (op_sub_i || (ext_a + ext_b != ext_p) || res_o == '0);
      // R5
      self_sub_chk: assert (!op_sub_i || a_i != b_i || res_o == '0);
    end
  end
endmodule

bind modp_addsub modp_addsub_chk #(.W(W), .PRIME(PRIME)) u_chk (
  .op_sub_i (op_sub_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .res_o    (res_o)
);

// File: tb/test_modp_addsub.sv
module test_modp_addsub;
  localparam int W = 256;
  localparam logic [W-1:0] P_REF =
    256'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_FFFFFC2F;

  logic         clk;
  logic         op_sub;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [W-1:0] res;

  int n_chk;
  int n_bad;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  modp_addsub i_modp_addsub (
    .op_sub_i (op_sub),
    .a_i      (a),
    .b_i      (b),
    .res_o    (res)
  );

  function automatic logic [W-1:0] ref_model(input logic sub, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] acc;
    if (sub) begin
      if (x >= y) acc = {1'b0, x} - {1'b0, y};
      else        acc = {1'b0, x} + {1'b0, P_REF} - {1'b0, y};
    end else begin
      acc = {1'b0, x} + {1'b0, y};
      if (acc >= {1'b0, P_REF}) acc = acc - {1'b0, P_REF};
    end
    return acc[W-1:0];
  endfunction

  function automatic logic [W-1:0] rand_elem();
    logic [W-1:0] v;
    for (int k = 0; k < W/32; k++) v[k*32 +: 32] = $urandom();
    if (v >= P_REF) v = v - P_REF;
    return v;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp);
    n_chk++;
    if (res !== exp || res >= P_REF) begin
      n_bad++;
      $display("FAIL %s op=%0b a=%h b=%h got=%h exp=%h", tag, op_sub, a, b, res, exp);
    end
  endtask

  task automatic apply(input string tag, input logic sub, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    op_sub = sub;
    a      = x;
    b      = y;
    #1;
    check(tag, ref_model(sub, x, y));
  endtask

  task automatic t_zero_inputs();
    apply("R1", 1'b0, '0, '0);
    check("R1", '0);
    apply("R2", 1'b1, '0, '0);
  endtask

  task automatic t_random_add();
    for (int i = 0; i < 200; i++) apply("R1", 1'b0, rand_elem(), rand_elem());
  endtask

  task automatic t_random_sub();
    for (int i = 0; i < 200; i++) apply("R2", 1'b1, rand_elem(), rand_elem());
  endtask

  task automatic t_sum_equals_p();
    logic [W-1:0] x;
    apply("R4", 1'b0, P_REF - 1, 256'd1);
    check("R4", '0);
    apply("R4", 1'b0, 256'd0, P_REF - 1);
    check("R4", P_REF - 1);
    for (int i = 0; i < 20; i++) begin
      x = rand_elem();
      apply("R4", 1'b0, x, (x == 0) ? 256'd0 : P_REF - x);
      check("R4", '0);
    end
  endtask

  task automatic t_equal_operands();
    logic [W-1:0] x;
    for (int i = 0; i < 20; i++) begin
      x = rand_elem();
      apply("R5", 1'b1, x, x);
      check("R5", '0);
    end
    apply("R5", 1'b1, P_REF - 1, P_REF - 1);
    check("R5", '0);
  endtask

  task automatic t_overflow();
    apply("R6", 1'b0, P_REF - 1, P_REF - 1);
    check("R6", P_REF - 2);
    apply("R6", 1'b0, P_REF - 1, 256'd2);
    check("R6", 256'd1);
    apply("R6", 1'b0, {1'b1, 255'd0}, {1'b1, 255'd0});
    check("R6", ~P_REF + 1);
  endtask

  task automatic t_zero_minuend();
    logic [W-1:0] y;
    apply("R7", 1'b1, '0, P_REF - 1);
    check("R7", 256'd1);
    apply("R7", 1'b1, '0, 256'd1);
    check("R7", P_REF - 1);
    for (int i = 0; i < 10; i++) begin
      y = rand_elem();
      apply("R7", 1'b1, '0, y);
      check("R7", (y == 0) ? 256'd0 : P_REF - y);
    end
  endtask

  task automatic t_history_free();
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [W-1:0] first;
    x = rand_elem();
    y = rand_elem();
    apply("R8", 1'b1, x, y);
    first = res;
    apply("R8", 1'b0, P_REF - 1, P_REF - 1);
    apply("R8", 1'b1, x, y);
    check("R8", first);
    // Change inputs between edges: output follows without a clock edge.
    #1;
    a = 256'd5;
    b = 256'd7;
    op_sub = 1'b0;
    #1;
    check("R8", 256'd12);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    n_chk  = 0;
    n_bad  = 0;
    op_sub = 1'b0;
    a      = '0;
    b      = '0;
    repeat (2) @(posedge clk);
    t_zero_inputs();
    t_sum_equals_p();
    t_overflow();
    t_equal_operands();
    t_zero_minuend();
    t_random_add();
    t_random_sub();
    t_history_free();
    finish_run();
  end
endmodule